// File: doc/BRIEF.md
# Interrupt Redirection Table Controller

This block gathers a parameterized set of interrupt input pins and turns activity on each one into an interrupt message. Each message carries an 8-bit vector, a 3-bit delivery mode and a 16-bit destination processor ID. Every pin owns a redirection entry that sets these values. The entry also selects edge or level triggering, sets the active polarity and holds a mask bit. Messages leave through a single valid/ready port. When several pins want service at once, the lowest-numbered pin goes first.

Software reaches everything through a 32-bit register bus with two indirect registers. An index register picks an internal register, and a window register reads or writes that register. A separate end-of-interrupt register takes a vector number and rearms level-triggered entries. A level entry that has delivered a message stays blocked until that write arrives. An edge that arrives while its entry is masked is discarded. Each pin is passed through a two-flop synchronizer before detection. Several level lines of the same polarity may be wired onto one pin, and the pin then responds to their combined level.

Top module: `irq_route_ctrl`

## Requirements
- R1: A write to bus offset 0x00 stores an 8-bit register index, and a read of 0x00 returns it in bits 7:0. Reads and writes at offset 0x10 reach the indexed register. Read data appears on bus_rdata in the cycle after the read request. An index that names no register reads as zero.
- R2: Index 0x01 is read-only. It reads as VERSION in bits 7:0 and NUM_PINS-1 in bits 23:16, with bits 15:8 and 31:24 reading as zero.
- R3: Pin n has a low word at index 0x10+2n. Its fields are vector [7:0], delivery mode [10:8] (0 fixed, 1 lowest priority, 2 PMI, 5 INIT), polarity [13] (1 = active low), trigger [15] (1 = level) and mask [16]. Its high word is at index 0x11+2n and holds the destination in [31:16]: processor ID in [31:24], extended ID in [23:16]. All other bits read as zero.
- R4: After reset, every low word reads 0x0001_0000 (masked) and every high word reads 0. The index register reads 0, and no message is offered.
- R5: For an unmasked edge entry, each inactive-to-active transition of the pin yields exactly one message carrying the entry's vector, mode and destination. A pin that stays active yields nothing more.
- R6: An edge that arrives while its entry is masked is dropped. No message for it appears after the entry is unmasked.
- R7: An unmasked level entry whose pin is active produces a message. Once that message is accepted, the entry produces no further message while the pin stays active.
- R8: A write to offset 0x40 carries a vector in bits 7:0 and rearms every level entry whose vector matches. A still-active pin then produces a new message. A write with a non-matching vector has no effect, and a rearmed entry whose pin is inactive stays silent.
- R9: When several pins request at once, the lowest-numbered pin's message is offered first.
- R10: While msg_valid is high and msg_ready is low, the message fields and msg_valid hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Register access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset: 0x00 index, 0x10 window, 0x40 end-of-interrupt |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| irq_pins | input | NUM_PINS | Asynchronous interrupt inputs |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_vector | output | 8 | Message vector |
| msg_mode | output | 3 | Message delivery mode |
| msg_dest | output | 16 | Message destination ID |

## Verification
The bench checks the case of an edge pulse arriving under mask. A design that latched such an edge would deliver a stray message at unmask, and the scoreboard flags any message it did not predict. It holds an active-low level pin asserted across end-of-interrupt writes with matching and non-matching vectors. A design that failed to block after acceptance would flood messages, and one that ignored the vector match would rearm on the wrong write. It raises two edge pins together while the receiver stalls. This catches a wrong priority order and fields that shift under backpressure. Reserved bits written as ones must read back as zero.

// File: rtl/irt_pkg.sv
package irt_pkg;

  // Bus offsets
  localparam logic [7:0] OFS_INDEX  = 8'h00;
  localparam logic [7:0] OFS_WINDOW = 8'h10;
  localparam logic [7:0] OFS_EOI    = 8'h40;

  // Indexed registers
  localparam logic [7:0] IDX_VERSION   = 8'h01;
  localparam int         IDX_TBL_BASE  = 16;

  // Writable bits of an entry low word, and its reset value (masked)
  localparam logic [31:0] LO_KEEP  = 32'h0001_A7FF;
  localparam logic [31:0] LO_RESET = 32'h0001_0000;

  typedef struct packed {
    logic [15:0] dest;
    logic        mask;
    logic        level;
    logic        pol;
    logic [2:0]  mode;
    logic [7:0]  vector;
  } irt_entry_t;

endpackage

// File: rtl/irt_sync.sv
module irt_sync #(
  parameter int WIDTH = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      d_sync <= '0;
    end else begin
      stage1 <= d_async;
      d_sync <= stage1;
    end
  end
endmodule

// File: rtl/irt_regs.sv
module irt_regs
  import irt_pkg::*;
#(
  parameter int         NUM_PINS = 24,
  parameter logic [7:0] VERSION  = 8'h21
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         bus_req,
  input  logic                         bus_we,
  input  logic [7:0]                   bus_addr,
  input  logic [31:0]                  bus_wdata,
  output logic [31:0]                  bus_rdata,
  output irt_entry_t [NUM_PINS-1:0]    ent,
  output logic                         eoi_stb,
  output logic [7:0]                   eoi_vec
);
  localparam logic [31:0] VER_WORD = {8'h00, 8'(NUM_PINS - 1), 8'h00, VERSION};

  logic [7:0]  sel;
  logic [31:0] tbl_lo [NUM_PINS];
  logic [15:0] tbl_hi [NUM_PINS];
  logic        wr_idx, wr_win, rd_any;
  logic [31:0] win_word, rd_word;

  assign wr_idx  = bus_req && bus_we && (bus_addr == OFS_INDEX);
  assign wr_win  = bus_req && bus_we && (bus_addr == OFS_WINDOW);
  assign rd_any  = bus_req && !bus_we;
  assign eoi_stb = bus_req && bus_we && (bus_addr == OFS_EOI);
  assign eoi_vec = bus_wdata[7:0];

  always_ff @(posedge clk) begin
    if (rst) sel <= '0;
    else if (wr_idx) sel <= bus_wdata[7:0];
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_PINS; i++) begin
      if (rst) begin
        tbl_lo[i] <= LO_RESET;
        tbl_hi[i] <= '0;
      end else if (wr_win) begin
        if (sel == 8'(IDX_TBL_BASE + 2*i))     tbl_lo[i] <= bus_wdata & LO_KEEP;
        if (sel == 8'(IDX_TBL_BASE + 2*i + 1)) tbl_hi[i] <= bus_wdata[31:16];
      end
    end
  end

  always_comb begin
    win_word = '0;
    if (sel == IDX_VERSION) win_word = VER_WORD;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (sel == 8'(IDX_TBL_BASE + 2*i))     win_word = tbl_lo[i];
      if (sel == 8'(IDX_TBL_BASE + 2*i + 1)) win_word = {tbl_hi[i], 16'h0000};
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_INDEX:  rd_word = {24'h0, sel};
      OFS_WINDOW: rd_word = win_word;
      default:    rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (rd_any) bus_rdata <= rd_word;
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_ent
    assign ent[g].dest   = tbl_hi[g];
    assign ent[g].mask   = tbl_lo[g][16];
    assign ent[g].level  = tbl_lo[g][15];
    assign ent[g].pol    = tbl_lo[g][13];
    assign ent[g].mode   = tbl_lo[g][10:8];
    assign ent[g].vector = tbl_lo[g][7:0];
  end

  // R2
  ver_rsvd_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_any && bus_addr == OFS_WINDOW && sel == IDX_VERSION)
      |=> (bus_rdata[31:24] == 8'h00 && bus_rdata[15:8] == 8'h00));
endmodule

// File: rtl/irt_pend.sv
module irt_pend #(
  parameter int NUM_PINS = 24,
  localparam int PW = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_PINS-1:0]      pin_s,
  input  logic [NUM_PINS-1:0]      mask_v,
  input  logic [NUM_PINS-1:0]      level_v,
  input  logic [NUM_PINS-1:0]      pol_v,
  input  logic [NUM_PINS-1:0][7:0] vec_v,
  input  logic                     eoi_stb,
  input  logic [7:0]               eoi_vec,
  input  logic                     acc_stb,
  input  logic [PW-1:0]            acc_pin,
  output logic [NUM_PINS-1:0]      req
);
  logic [NUM_PINS-1:0] active, prev_act, edge_pend, rirr;

  assign active = pin_s ^ pol_v;

  always_ff @(posedge clk) begin
    if (rst) prev_act <= '0;
    else     prev_act <= active;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_PINS; i++) begin
      if (rst) begin
        edge_pend[i] <= 1'b0;
        rirr[i]      <= 1'b0;
      end else begin
        // Edge capture: masked or level entries keep nothing pending
        if (mask_v[i] || level_v[i])               edge_pend[i] <= 1'b0;
        else if (active[i] && !prev_act[i])        edge_pend[i] <= 1'b1;
        else if (acc_stb && acc_pin == PW'(i))     edge_pend[i] <= 1'b0;
        // Level block flag: set on acceptance, cleared by matching EOI
        if (acc_stb && acc_pin == PW'(i) && level_v[i]) rirr[i] <= 1'b1;
        else if (eoi_stb && vec_v[i] == eoi_vec)        rirr[i] <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_req
    assign req[g] = level_v[g] ? (active[g] && !mask_v[g] && !rirr[g]) : edge_pend[g];
  end
endmodule

// File: rtl/irt_pick.sv
module irt_pick #(
  parameter int NUM_PINS = 24,
  localparam int PW = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_PINS-1:0]       req,
  input  logic [NUM_PINS-1:0][7:0]  vec_v,
  input  logic [NUM_PINS-1:0][2:0]  mode_v,
  input  logic [NUM_PINS-1:0][15:0] dest_v,
  input  logic                      msg_ready,
  output logic                      msg_valid,
  output logic [7:0]                msg_vector,
  output logic [2:0]                msg_mode,
  output logic [15:0]               msg_dest,
  output logic                      acc_stb,
  output logic [PW-1:0]             acc_pin
);
  logic          found;
  logic [PW-1:0] win;

  always_comb begin
    found = 1'b0;
    win   = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        win   = PW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_valid  <= 1'b0;
      msg_vector <= '0;
      msg_mode   <= '0;
      msg_dest   <= '0;
      acc_pin    <= '0;
    end else if (!msg_valid && found) begin
      msg_valid  <= 1'b1;
      msg_vector <= vec_v[win];
      msg_mode   <= mode_v[win];
      msg_dest   <= dest_v[win];
      acc_pin    <= win;
    end else if (msg_valid && msg_ready) begin
      msg_valid  <= 1'b0;
    end
  end

  assign acc_stb = msg_valid && msg_ready;

  // R10
  msg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector)
      && $stable(msg_mode) && $stable(msg_dest)));
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irt_pkg::*;
#(
  parameter int         NUM_PINS = 24,
  parameter logic [7:0] VERSION  = 8'h21
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_req,
  input  logic                bus_we,
  input  logic [7:0]          bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] irq_pins,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic [7:0]          msg_vector,
  output logic [2:0]          msg_mode,
  output logic [15:0]         msg_dest
);
  localparam int PW = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  irt_entry_t [NUM_PINS-1:0]  ent;
  logic [NUM_PINS-1:0]        pin_s, mask_v, level_v, pol_v, req;
  logic [NUM_PINS-1:0][7:0]   vec_v;
  logic [NUM_PINS-1:0][2:0]   mode_v;
  logic [NUM_PINS-1:0][15:0]  dest_v;
  logic                       eoi_stb, acc_stb;
  logic [7:0]                 eoi_vec;
  logic [PW-1:0]              acc_pin;

  irt_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk(clk), .rst(rst), .d_async(irq_pins), .d_sync(pin_s));

  irt_regs #(.NUM_PINS(NUM_PINS), .VERSION(VERSION)) u_regs (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ent(ent), .eoi_stb(eoi_stb), .eoi_vec(eoi_vec));

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_split
    assign mask_v[g]  = ent[g].mask;
    assign level_v[g] = ent[g].level;
    assign pol_v[g]   = ent[g].pol;
    assign vec_v[g]   = ent[g].vector;
    assign mode_v[g]  = ent[g].mode;
    assign dest_v[g]  = ent[g].dest;
  end

  irt_pend #(.NUM_PINS(NUM_PINS)) u_pend (
    .clk(clk), .rst(rst), .pin_s(pin_s), .mask_v(mask_v), .level_v(level_v),
    .pol_v(pol_v), .vec_v(vec_v), .eoi_stb(eoi_stb), .eoi_vec(eoi_vec),
    .acc_stb(acc_stb), .acc_pin(acc_pin), .req(req));

  irt_pick #(.NUM_PINS(NUM_PINS)) u_pick (
    .clk(clk), .rst(rst), .req(req), .vec_v(vec_v), .mode_v(mode_v),
    .dest_v(dest_v), .msg_ready(msg_ready), .msg_valid(msg_valid),
    .msg_vector(msg_vector), .msg_mode(msg_mode), .msg_dest(msg_dest),
    .acc_stb(acc_stb), .acc_pin(acc_pin));

  // Checker state: remembers a just-accepted level message
  logic          chk_lvl_acc;
  logic [PW-1:0] chk_pin;
  always_ff @(posedge clk) begin
    if (rst) begin
      chk_lvl_acc <= 1'b0;
      chk_pin     <= '0;
    end else begin
      chk_lvl_acc <= acc_stb && level_v[acc_pin];
      chk_pin     <= acc_pin;
    end
  end

  // R7
  rirr_block_chk: assert property (@(posedge clk) disable iff (rst)
    chk_lvl_acc |-> !req[chk_pin]);

  // R5
  req_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(msg_valid) |-> $past(|req));

  // R4
  rst_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !msg_valid);
endmodule

// File: tb/irq_route_ctrl_bench.sv
module irq_route_ctrl_bench;
  localparam int NP = 24;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NP-1:0] irq_pins = '0;
  logic        msg_valid, msg_ready = 1'b1;
  logic [7:0]  msg_vector;
  logic [2:0]  msg_mode;
  logic [15:0] msg_dest;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  string cur_tag = "R5";
  logic [26:0] exp_q [$];

  always #10 clk = ~clk;

  irq_route_ctrl #(.NUM_PINS(NP), .VERSION(8'h21)) u_irq_route_ctrl (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_pins(irq_pins), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_vector(msg_vector), .msg_mode(msg_mode), .msg_dest(msg_dest));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Monitor: pops the scoreboard on every accepted message
  initial begin
    forever begin
      @(negedge clk); #5;
      if (!rst && msg_valid && msg_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, {cur_tag, " unexpected message"}, {5'h0, msg_vector, msg_mode, msg_dest}, 32'h0);
        end else begin
          logic [26:0] e;
          e = exp_q.pop_front();
          check({msg_vector, msg_mode, msg_dest} == e, {cur_tag, " message"},
                {5'h0, msg_vector, msg_mode, msg_dest}, {5'h0, e});
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
    check(bus_rdata == exp, tag, bus_rdata, exp);
  endtask

  task automatic idx_wr(input logic [7:0] idx, input logic [31:0] d);
    wr(8'h00, {24'h0, idx});
    wr(8'h10, d);
  endtask

  task automatic idx_chk(input logic [7:0] idx, input logic [31:0] exp, input string tag);
    wr(8'h00, {24'h0, idx});
    rd_chk(8'h10, exp, tag);
  endtask

  task automatic expect_msg(input logic [7:0] v, input logic [2:0] m, input logic [15:0] d);
    exp_q.push_back({v, m, d});
  endtask

  task automatic drain_chk(input string tag);
    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, {tag, " scoreboard drained"}, exp_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R4 reset state
    check(msg_valid == 1'b0, "R4 no message after reset", msg_valid, 0);
    rd_chk(8'h00, 32'h0, "R4 index reset");
    idx_chk(8'h10, 32'h0001_0000, "R4 entry0 low masked");
    idx_chk(8'h3F, 32'h0, "R4 entry23 high");

    // R2 version
    idx_chk(8'h01, 32'h0017_0021, "R2 version word");

    // R1 index readback and unknown indices
    wr(8'h00, 32'h15);
    rd_chk(8'h00, 32'h15, "R1 index readback");
    idx_chk(8'h02, 32'h0, "R1 unknown index");
    idx_chk(8'h40, 32'h0, "R1 beyond table");

    // R3 entry 3 layout, reserved bits dropped
    idx_wr(8'h16, 32'hFFFE_5941);
    idx_chk(8'h16, 32'h0000_0141, "R3 low word");
    idx_wr(8'h17, 32'h1234_ABCD);
    idx_chk(8'h17, 32'h1234_0000, "R3 high word");

    // R5 edge pulse, then held-high level yields one message each
    cur_tag = "R5";
    expect_msg(8'h41, 3'd1, 16'h1234);
    irq_pins[3] = 1'b1; repeat (3) @(negedge clk); irq_pins[3] = 1'b0;
    drain_chk("R5 pulse");
    expect_msg(8'h41, 3'd1, 16'h1234);
    irq_pins[3] = 1'b1; repeat (20) @(negedge clk); irq_pins[3] = 1'b0;
    drain_chk("R5 held high");

    // R6 edge under mask is discarded
    cur_tag = "R6";
    idx_wr(8'h16, 32'h0001_0141);
    irq_pins[3] = 1'b1; repeat (4) @(negedge clk); irq_pins[3] = 1'b0;
    repeat (8) @(negedge clk);
    idx_wr(8'h16, 32'h0000_0141);
    drain_chk("R6 masked edge");

    // R7 level, active low, PMI mode on pin 5
    cur_tag = "R7";
    irq_pins[5] = 1'b1;
    idx_wr(8'h1B, 32'hAB01_0000);
    idx_wr(8'h1A, 32'h0000_A252);
    drain_chk("R7 inactive pin");
    expect_msg(8'h52, 3'd2, 16'hAB01);
    irq_pins[5] = 1'b0;
    drain_chk("R7 single level message");

    // R8 end of interrupt
    cur_tag = "R8";
    wr(8'h40, 32'h53);
    drain_chk("R8 mismatched EOI");
    expect_msg(8'h52, 3'd2, 16'hAB01);
    wr(8'h40, 32'h52);
    drain_chk("R8 matching EOI rearms");
    irq_pins[5] = 1'b1;
    repeat (5) @(negedge clk);
    wr(8'h40, 32'h52);
    drain_chk("R8 EOI with inactive pin");

    // R9 priority and R10 hold under backpressure
    cur_tag = "R9";
    msg_ready = 1'b0;
    idx_wr(8'h19, 32'h0400_0000);
    idx_wr(8'h18, 32'h0000_0044);
    idx_wr(8'h1F, 32'h0700_0000);
    idx_wr(8'h1E, 32'h0000_0047);
    irq_pins[4] = 1'b1; irq_pins[7] = 1'b1;
    repeat (8) @(negedge clk);
    check(msg_valid && msg_vector == 8'h44, "R9 lowest pin first", {23'h0, msg_valid, msg_vector}, 32'h144);
    repeat (3) @(negedge clk);
    check(msg_valid && msg_vector == 8'h44 && msg_dest == 16'h0400 && msg_mode == 3'd0,
          "R10 held under stall", {msg_vector, msg_dest, 5'h0, msg_mode}, {8'h44, 16'h0400, 8'h00});
    expect_msg(8'h44, 3'd0, 16'h0400);
    expect_msg(8'h47, 3'd0, 16'h0700);
    msg_ready = 1'b1;
    drain_chk("R9 both delivered in order");
    irq_pins[4] = 1'b0; irq_pins[7] = 1'b0;
    repeat (5) @(negedge clk);

    done = 1'b1;
    finish_run();
  end
endmodule